// File: doc/BRIEF.md
# Peripheral protection port permission controller

This block keeps the access-control state of one group of protected peripheral ports, up to sixteen of them. Three permission words are stored: a security word that marks each port non-secure or secure, a privilege word used for secure ports, and a privilege word used for non-secure ports. Each word has its own write strobe, which comes from the register bank that owns it. The non-secure privilege strobe comes from the non-secure bank, and the other two come from the secure bank. Address decoding is done outside this block.

From the stored words the block drives one security output and one privilege output per port. It also connects the group to its parent's shared interrupt registers through a fixed bit position, `IRQ_OFFSET`. The group takes its enable and clear levels from that bit of the parent's enable and status words. It returns its own level interrupt-status input at that same bit of a 32-bit contribution word, which the parent merges into its status register.

Top module: `ppc_port_ctrl`

## Requirements
- R1: While rst_ni is low, the three words reset to zero. ns_o, priv_o, irq_en_o, irq_clr_o and stat_o all read zero.
- R2: Only bits 0 to NUMPORTS-1 of wdata_i are stored. Bits of ns_o and priv_o at positions NUMPORTS and above are always zero.
- R3: After a clock edge at which ns_we_i is high, ns_o equals wdata_i masked to NUMPORTS bits.
- R4: For each port i, priv_o[i] follows the security bit. When ns_o[i] is 1, priv_o[i] is bit i of the non-secure privilege word. When ns_o[i] is 0, priv_o[i] is bit i of the secure privilege word.
- R5: A write to any one word updates priv_o at the same edge. If several strobes are high in one cycle, every addressed word takes wdata_i, and priv_o is derived from the new values of all of them.
- R6: A word whose strobe is low keeps its value. Writing one word does not change the other two.
- R7: irq_en_o equals en_word_i[IRQ_OFFSET] as sampled at the previous clock edge.
- R8: irq_clr_o equals stat_word_i[IRQ_OFFSET] as sampled at the previous clock edge.
- R9: stat_o carries status_i, as sampled at the previous clock edge, at bit IRQ_OFFSET. All other bits of stat_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 32 | Write data shared by the three words |
| ns_we_i | input | 1 | Write strobe for the security word (secure bank) |
| sp_we_i | input | 1 | Write strobe for the secure privilege word (secure bank) |
| nsp_we_i | input | 1 | Write strobe for the non-secure privilege word (non-secure bank) |
| en_word_i | input | 32 | Parent interrupt-enable word |
| stat_word_i | input | 32 | Parent interrupt-status word |
| status_i | input | 1 | Level interrupt status from the protected bus segment |
| ns_o | output | 16 | Per-port non-secure marking |
| priv_o | output | 16 | Per-port access-privilege level |
| irq_en_o | output | 1 | Group interrupt enable |
| irq_clr_o | output | 1 | Group interrupt clear |
| stat_o | output | 32 | Status contribution at bit IRQ_OFFSET |

## Verification
A change of the security word and a change of a privilege word can both land on the same clock edge. When they do, priv_o must select using the new security bits and the new privilege bits together, never mixing an old word with a new one. The bench forces this overlap with directed cycles that raise two or all three strobes at once. It also lets randomly driven strobes overlap freely over several hundred cycles. A behavioural model applies every strobe of a cycle before it recomputes the selection. The design's ports are then compared with that model on every cycle.

// File: rtl/ppc_perm_pkg.sv
package ppc_perm_pkg;
  localparam int unsigned MAX_PORTS = 16;
  localparam int unsigned DATA_W    = 32;

  typedef logic [MAX_PORTS-1:0] port_vec_t;
  typedef logic [DATA_W-1:0]    data_t;

  function automatic data_t port_mask(input int unsigned n);
    data_t m;
    m = '0;
    for (int unsigned i = 0; i < MAX_PORTS; i++)
      if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ppc_perm_word.sv
module ppc_perm_word
  import ppc_perm_pkg::*;
#(
  parameter int unsigned NUMPORTS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  port_vec_t wdata_i,
  output port_vec_t word_o
);
  for (genvar i = 0; i < MAX_PORTS; i++) begin : g_bit
    if (i < NUMPORTS) begin : g_live
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b0;
        else if (we_i) q <= wdata_i[i];
      end
      assign word_o[i] = q;
    end else begin : g_tie
      assign word_o[i] = 1'b0;
    end
  end

  a_r6_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(word_o));
  a_r2_masked_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> word_o == ($past(wdata_i) & MAX_PORTS'(port_mask(NUMPORTS))));
endmodule

// File: rtl/ppc_priv_sel.sv
module ppc_priv_sel
  import ppc_perm_pkg::*;
#(
  parameter int unsigned NUMPORTS = 16
) (
  input  port_vec_t ns_i,
  input  port_vec_t sp_i,
  input  port_vec_t nsp_i,
  output port_vec_t priv_o
);
  for (genvar i = 0; i < MAX_PORTS; i++) begin : g_port
    if (i < NUMPORTS) begin : g_live
      assign priv_o[i] = ns_i[i] ? nsp_i[i] : sp_i[i];
    end else begin : g_tie
      logic unused;
      assign unused    = ns_i[i] ^ sp_i[i] ^ nsp_i[i];
      assign priv_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ppc_irq_tap.sv
module ppc_irq_tap
  import ppc_perm_pkg::*;
#(
  parameter int unsigned IRQ_OFFSET = 0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  data_t en_word_i,
  input  data_t stat_word_i,
  input  logic  status_i,
  output logic  irq_en_o,
  output logic  irq_clr_o,
  output data_t stat_o
);
  logic status_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o  <= 1'b0;
      irq_clr_o <= 1'b0;
      status_q  <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      irq_en_o  <= en_word_i[IRQ_OFFSET];
      irq_clr_o <= stat_word_i[IRQ_OFFSET];
      status_q  <= status_i;
      armed_q   <= 1'b1;
    end
  end

  always_comb begin
    stat_o             = '0;
    stat_o[IRQ_OFFSET] = status_q;
  end

  a_r7_enable_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> irq_en_o == (($past(en_word_i) >> IRQ_OFFSET) & 1) != 0);
  a_r8_clear_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> irq_clr_o == (($past(stat_word_i) >> IRQ_OFFSET) & 1) != 0);
  a_r9_single_status_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_o) && (armed_q -> (stat_o[IRQ_OFFSET] == $past(status_i))));
endmodule

// File: rtl/ppc_port_ctrl.sv
module ppc_port_ctrl
  import ppc_perm_pkg::*;
#(
  parameter int unsigned NUMPORTS   = 16,
  parameter int unsigned IRQ_OFFSET = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 ns_we_i,
  input  logic                 sp_we_i,
  input  logic                 nsp_we_i,
  input  logic [DATA_W-1:0]    en_word_i,
  input  logic [DATA_W-1:0]    stat_word_i,
  input  logic                 status_i,
  output logic [MAX_PORTS-1:0] ns_o,
  output logic [MAX_PORTS-1:0] priv_o,
  output logic                 irq_en_o,
  output logic                 irq_clr_o,
  output logic [DATA_W-1:0]    stat_o
);
  localparam data_t     MASK      = port_mask(NUMPORTS);
  localparam port_vec_t PORT_MASK = MASK[MAX_PORTS-1:0];

  if (NUMPORTS < 1 || NUMPORTS > MAX_PORTS) begin : g_bad_ports
    initial $error("NUMPORTS out of range");
  end
  if (IRQ_OFFSET >= DATA_W) begin : g_bad_offset
    initial $error("IRQ_OFFSET out of range");
  end

  port_vec_t ns_w, sp_w, nsp_w;
  port_vec_t wdata_lo;
  assign wdata_lo = wdata_i[MAX_PORTS-1:0];

  ppc_perm_word #(.NUMPORTS(NUMPORTS)) u_ns_word (
    .clk_i, .rst_ni, .we_i(ns_we_i),  .wdata_i(wdata_lo), .word_o(ns_w));
  ppc_perm_word #(.NUMPORTS(NUMPORTS)) u_sp_word (
    .clk_i, .rst_ni, .we_i(sp_we_i),  .wdata_i(wdata_lo), .word_o(sp_w));
  ppc_perm_word #(.NUMPORTS(NUMPORTS)) u_nsp_word (
    .clk_i, .rst_ni, .we_i(nsp_we_i), .wdata_i(wdata_lo), .word_o(nsp_w));

  ppc_priv_sel #(.NUMPORTS(NUMPORTS)) u_priv_sel (
    .ns_i(ns_w), .sp_i(sp_w), .nsp_i(nsp_w), .priv_o(priv_o));

  assign ns_o = ns_w;

  ppc_irq_tap #(.IRQ_OFFSET(IRQ_OFFSET)) u_irq_tap (
    .clk_i, .rst_ni,
    .en_word_i, .stat_word_i, .status_i,
    .irq_en_o, .irq_clr_o, .stat_o);

  a_r3_ns_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_we_i |=> ns_o == MAX_PORTS'($past(wdata_i) & MASK));
  a_r2_upper_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ns_o | priv_o) & ~PORT_MASK) == '0);
  a_r5_joint_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_we_i && sp_we_i && nsp_we_i) |=> priv_o == MAX_PORTS'($past(wdata_i) & MASK));
  a_r4_secure_port_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ns_we_i && !sp_we_i && !nsp_we_i) |=> $stable(priv_o));
endmodule

// File: tb/ppc_port_ctrl_bench.sv
module ppc_port_ctrl_bench;
  localparam int NP  = 12;
  localparam int OFF = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0, en_word = '0, stat_word = '0;
  logic        ns_we = 0, sp_we = 0, nsp_we = 0, status = 0;
  logic [15:0] ns_o, priv_o;
  logic        irq_en_o, irq_clr_o;
  logic [31:0] stat_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ppc_port_ctrl #(.NUMPORTS(NP), .IRQ_OFFSET(OFF)) u_ppc_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata),
    .ns_we_i(ns_we), .sp_we_i(sp_we), .nsp_we_i(nsp_we),
    .en_word_i(en_word), .stat_word_i(stat_word), .status_i(status),
    .ns_o, .priv_o, .irq_en_o, .irq_clr_o, .stat_o);

  // behavioural reference
  int m_ns, m_sp, m_nsp;
  bit m_en, m_clr, m_st;
  localparam int MASK = (1 << NP) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ns = 0; m_sp = 0; m_nsp = 0; m_en = 0; m_clr = 0; m_st = 0;
    end else begin
      if (ns_we)  m_ns  = wdata & MASK;
      if (sp_we)  m_sp  = wdata & MASK;
      if (nsp_we) m_nsp = wdata & MASK;
      m_en  = en_word[OFF];
      m_clr = stat_word[OFF];
      m_st  = status;
    end
  end

  function automatic int exp_priv();
    int r = 0;
    for (int i = 0; i < 16; i++)
      if (((m_ns >> i) & 1) != 0) r |= m_nsp & (1 << i);
      else                        r |= m_sp  & (1 << i);
    return r;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 ns_o", ns_o, m_ns);
    check("R4 priv_o", priv_o, exp_priv());
    check("R7 irq_en_o", irq_en_o, m_en);
    check("R8 irq_clr_o", irq_clr_o, m_clr);
    check("R9 stat_o", stat_o, longint'(m_st) << OFF);
    check("R2 upper bits", (ns_o | priv_o) & ~16'(MASK), 0);
  endtask

  always @(negedge clk) if (rst_n) compare_all();

  task automatic drive(input logic [31:0] d, input bit a, input bit b, input bit c);
    @(negedge clk);
    #0.5;
    wdata = d; ns_we = a; sp_we = b; nsp_we = c;
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state while reset held, with activity on the inputs
    en_word = '1; stat_word = '1; status = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ns_o", ns_o, 0);
    check("R1 reset priv_o", priv_o, 0);
    check("R1 reset irq", {irq_en_o, irq_clr_o}, 0);
    check("R1 reset stat_o", stat_o, 0);
    en_word = '0; stat_word = '0; status = 0;
    @(negedge clk); rst_n = 1;

    // R2: high bits written are dropped
    drive(32'hFFFF_FFFF, 1, 0, 0);
    drive(32'h0, 0, 0, 0);
    @(negedge clk); #1;
    check("R2 ns_o masked", ns_o, 16'h0FFF);
    // R6: secure privilege then non-secure privilege, others held
    drive(32'h0000_0A5A, 0, 1, 0);
    drive(32'h0000_05A5, 0, 0, 1);
    drive(32'h0, 0, 0, 0);
    @(negedge clk); #1;
    check("R6 ns held", ns_o, 16'h0FFF);
    check("R4 priv from nsp word", priv_o, 16'h05A5);
    drive(32'h0000_00F0, 1, 0, 0);
    drive(32'h0, 0, 0, 0);
    @(negedge clk); #1;
    check("R4 mixed select", priv_o, 16'h0A0A | 16'h00A0);
    // R5: security and privilege written together
    drive(32'h0000_0F0F, 1, 1, 0);
    drive(32'h0, 0, 0, 0);
    @(negedge clk); #1;
    check("R5 joint ns+sp", priv_o, (16'h05A5 & 16'h0F0F) | (16'h0F0F & ~16'h0F0F));
    drive(32'hABCD_1234, 1, 1, 1);
    drive(32'h0, 0, 0, 0);
    @(negedge clk); #1;
    check("R5 all three", priv_o, 16'h0234);

    // interrupt taps
    @(negedge clk); en_word = 32'h1 << OFF; stat_word = 32'hFFFF_FFFF ^ (32'h1 << OFF); status = 1;
    @(negedge clk); #1;
    check("R7 enable bit", irq_en_o, 1);
    check("R8 other bits ignored", irq_clr_o, 0);
    check("R9 status placed", stat_o, 32'h1 << OFF);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      #0.5;
      wdata = $urandom; ns_we = $urandom_range(0, 1);
      sp_we = $urandom_range(0, 1); nsp_we = $urandom_range(0, 1);
      en_word = $urandom; stat_word = $urandom; status = $urandom_range(0, 1);
    end
    drive(32'h0, 0, 0, 0);
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule